// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a time-base tick stream into a programmable periodic interrupt and a square-wave output. It counts `base_tick` pulses, each one a cycle of the time-base oscillator, in a binary divider chain. A 4-bit rate code picks which power-of-two boundary of that chain raises the periodic flag. A 3-bit divider code tells the block which oscillator frequency it is being fed, or holds the chain in reset.

Alarm and update-ended events come from outside as one-cycle pulses. The block only latches them. Three flags share a read-only status register with a combined request bit, and that request bit drives the `irq` output. Reading the status register clears every flag on the next cycle. A source is included in the request only if its enable bit is set.

Top module: `pirq_rate_gen`

## Requirements
- R1: The registers are at these addresses. Address 0 is control: divider code in bits 6:4, rate code in bits 3:0, bit 7 reads 0. Address 1 is enables: square-wave at bit 3, update at bit 4, alarm at bit 5, periodic at bit 6, all other bits read 0. Address 2 is the flag register. Address 3 reads 0. After reset, control reads 0x60 and the other two registers read 0.
- R2: Rate code 0 never sets the periodic flag and keeps `sqw` low, even when the divider is running and both enables are set.
- R3: The full period in base ticks depends on the divider code. Divider 0 (4 MHz class): 2^(n+FAST_LOG2-16). Divider 1 (1 MHz class): 2^(n+MID_LOG2-16). Divider 2 (32.768 kHz): 2^(n-1) for codes 3..15, and 2^(n+6) for codes 1 and 2 (256 Hz and 128 Hz).
- R4: Only divider codes 0, 1 and 2 run the chain. Any other code holds the chain at zero, so no periodic flag is set and `sqw` stays low. After a write that makes the chain run, the first periodic flag appears exactly one full period of ticks after that write edge.
- R5: In the flag register, bit 4 is update, bit 5 is alarm, bit 6 is periodic and bits 3:0 read 0. Each flag is set by its event whether or not its enable bit is set.
- R6: Flag bit 7 is the OR of each flag ANDed with its enable bit. `irq` equals bit 7.
- R7: A read of address 2 returns the current flags and clears them all on the next edge. An event arriving in that same cycle is kept.
- R8: When the square-wave enable is set, the rate code is non-zero and the chain runs, `sqw` toggles every half period. Otherwise `sqw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One pulse per time-base oscillator cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at address 2) |
| addr | input | 2 | Register address |
| wdata | input | 7 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| alarm_evt | input | 1 | One-cycle alarm event pulse |
| update_evt | input | 1 | One-cycle update-ended event pulse |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
The bench builds the block with the default FAST_LOG2=22 and MID_LOG2=20 and drives `base_tick` either on every cycle or on every eighth cycle. With those settings, the fast rate codes of all three time bases give periods of 32 to 16384 cycles, so the exact spacing can be measured for the code 1/2 exception of the 32.768 kHz base, for the low codes of the fast bases and for the slowest code of the slow base. The slowest codes of the 4 MHz class (2^21 ticks) use the same mask logic but are not timed.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_EN   = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        DIV_FAST = 3'd0,
        DIV_MID  = 3'd1,
        DIV_SLOW = 3'd2
    } div_sel_e;

    localparam logic [6:0] CTRL_RESET = 7'h60;

    // enable register packing (internal index, visible bit = index + 3)
    localparam int EN_SQ  = 0;
    localparam int EN_UPD = 1;
    localparam int EN_ALM = 2;
    localparam int EN_PER = 3;

    typedef struct packed {
        logic [6:0] ctrl;
        logic [3:0] en;
    } regs_t;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flags_t;

endpackage

// File: rtl/pirq_rate_dec.sv
module pirq_rate_dec #(
    parameter int FAST_LOG2 = 22,
    parameter int MID_LOG2  = 20,
    parameter int EXP_W     = 5
) (
    input  logic [2:0]       div_sel,
    input  logic [3:0]       rate_sel,
    output logic             run,
    output logic             active,
    output logic [EXP_W-1:0] half_exp
);
    import pirq_pkg::*;

    int exp_v;

    always_comb begin
        run   = 1'b0;
        exp_v = 0;
        case (div_sel)
            DIV_FAST: begin
                run   = 1'b1;
                exp_v = int'(rate_sel) + FAST_LOG2 - 17;
            end
            DIV_MID: begin
                run   = 1'b1;
                exp_v = int'(rate_sel) + MID_LOG2 - 17;
            end
            DIV_SLOW: begin
                run   = 1'b1;
                // codes 1 and 2 fall back to 256 Hz / 128 Hz on the slow base
                exp_v = (rate_sel < 4'd3) ? int'(rate_sel) + 5 : int'(rate_sel) - 2;
            end
            default: run = 1'b0;
        endcase
        active   = run && (rate_sel != 4'd0);
        half_exp = EXP_W'(exp_v);
    end

endmodule

// File: rtl/pirq_div_chain.sv
module pirq_div_chain #(
    parameter int CHAIN_W = 21,
    parameter int EXP_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             run,
    input  logic             active,
    input  logic             sq_en,
    input  logic [EXP_W-1:0] half_exp,
    output logic             per_evt,
    output logic             sqw
);

    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic               sq;
    } chain_t;

    chain_t st_d, st_q;
    logic [CHAIN_W-1:0] half_mask, full_mask;
    logic half_hit;

    always_comb begin
        half_mask = (CHAIN_W'(1) << half_exp) - CHAIN_W'(1);
        full_mask = {half_mask[CHAIN_W-2:0], 1'b1};
        half_hit  = base_tick && active && ((st_q.cnt & half_mask) == half_mask);
        per_evt   = base_tick && active && ((st_q.cnt & full_mask) == full_mask);

        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (base_tick) begin
            st_d.cnt = st_q.cnt + CHAIN_W'(1);
        end

        if (active && sq_en) begin
            st_d.sq = half_hit ? ~st_q.sq : st_q.sq;
        end else begin
            st_d.sq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqw = st_q.sq;

    a_r4_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

    a_r8_sq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && sq_en) |=> !sqw);

endmodule

// File: rtl/pirq_flags.sv
module pirq_flags (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   per_evt,
    input  logic                   alarm_evt,
    input  logic                   update_evt,
    input  logic                   rd_clr,
    input  logic                   en_per,
    input  logic                   en_alm,
    input  logic                   en_upd,
    output pirq_pkg::flags_t       flags,
    output logic                   irqf
);
    import pirq_pkg::*;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = rd_clr ? '0 : fl_q;
        fl_d.pf = fl_d.pf | per_evt;
        fl_d.af = fl_d.af | alarm_evt;
        fl_d.uf = fl_d.uf | update_evt;
        irqf = (fl_q.pf && en_per) || (fl_q.af && en_alm) || (fl_q.uf && en_upd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    a_r7_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !per_evt && !alarm_evt && !update_evt) |=> (flags == '0));

    a_r5_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flags.af);

    a_r5_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> flags.uf);

endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen #(
    parameter int FAST_LOG2 = 22,
    parameter int MID_LOG2  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [6:0] wdata,
    output logic [7:0] rdata,
    input  logic       alarm_evt,
    input  logic       update_evt,
    output logic       irq,
    output logic       sqw
);
    import pirq_pkg::*;

    localparam int CHAIN_W = FAST_LOG2 - 1;
    localparam int EXP_W   = $clog2(FAST_LOG2);

    regs_t  rg_d, rg_q;
    logic   run, active, per_evt, irqf, rd_clr;
    logic [EXP_W-1:0] half_exp;
    flags_t flags;

    always_comb begin
        rg_d = rg_q;
        if (wr_en && addr == ADDR_CTRL) rg_d.ctrl = wdata;
        if (wr_en && addr == ADDR_EN)   rg_d.en   = wdata[6:3];
        rd_clr = rd_en && (addr == ADDR_FLAG);
        case (addr)
            ADDR_CTRL: rdata = {1'b0, rg_q.ctrl};
            ADDR_EN:   rdata = {1'b0, rg_q.en, 3'b000};
            ADDR_FLAG: rdata = {irqf, flags.pf, flags.af, flags.uf, 4'b0000};
            default:   rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{ctrl: CTRL_RESET, en: 4'b0000};
        end else begin
            rg_q <= rg_d;
        end
    end

    pirq_rate_dec #(
        .FAST_LOG2(FAST_LOG2),
        .MID_LOG2 (MID_LOG2),
        .EXP_W    (EXP_W)
    ) u_dec (
        .div_sel (rg_q.ctrl[6:4]),
        .rate_sel(rg_q.ctrl[3:0]),
        .run     (run),
        .active  (active),
        .half_exp(half_exp)
    );

    pirq_div_chain #(
        .CHAIN_W(CHAIN_W),
        .EXP_W  (EXP_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .run      (run),
        .active   (active),
        .sq_en    (rg_q.en[EN_SQ]),
        .half_exp (half_exp),
        .per_evt  (per_evt),
        .sqw      (sqw)
    );

    pirq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_evt   (per_evt),
        .alarm_evt (alarm_evt),
        .update_evt(update_evt),
        .rd_clr    (rd_clr),
        .en_per    (rg_q.en[EN_PER]),
        .en_alm    (rg_q.en[EN_ALM]),
        .en_upd    (rg_q.en[EN_UPD]),
        .flags     (flags),
        .irqf      (irqf)
    );

    assign irq = irqf;

    // R6: a request can only appear after an event or an enable write
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(alarm_evt || update_evt || per_evt ||
                             (wr_en && addr == ADDR_EN)));

    // R2: a zero rate code never produces a periodic event
    a_r2_no_pf_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ctrl[3:0] == 4'd0 && !rd_clr && !flags.pf) |=> !flags.pf);

endmodule

// File: tb/pirq_rate_gen_tb_top.sv
`timescale 1ns/1ps
module pirq_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [6:0] wdata = 7'd0;
    logic [7:0] rdata;
    logic       alarm_evt = 1'b0, update_evt = 1'b0;
    logic       irq, sqw;

    int checks = 0, errors = 0, cyc = 0;
    int stride = 1, ph = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        base_tick <= (ph == stride - 1);
        ph        <= (ph >= stride - 1) ? 0 : ph + 1;
    end

    pirq_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .alarm_evt(alarm_evt), .update_evt(update_evt),
        .irq(irq), .sqw(sqw)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #2;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input bit alarm);
        @(negedge clk);
        if (alarm) alarm_evt = 1'b1; else update_evt = 1'b1;
        @(posedge clk); #2;
        alarm_evt = 1'b0; update_evt = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int t, output bit ok);
        ok = 1'b0; t = 0;
        for (int i = 0; i < limit; i++) begin
            if (irq) begin ok = 1'b1; t = cyc; break; end
            @(posedge clk); #2;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        rd(2'd0, d); chk(d, 8'h60, "R1 control reset");
        rd(2'd1, d); chk(d, 0, "R1 enable reset");
        rd(2'd2, d); chk(d, 0, "R1 flag reset");
        chk(irq, 0, "R6 irq reset");
        chk(sqw, 0, "R8 sqw reset");
    endtask

    task automatic t_reg_access();
        logic [7:0] d;
        wr(2'd0, 7'h7F); rd(2'd0, d); chk(d, 8'h7F, "R1 control readback");
        wr(2'd1, 7'h7F); rd(2'd1, d); chk(d, 8'h78, "R1 enable readback");
        rd(2'd3, d); chk(d, 0, "R1 reserved address");
        wr(2'd1, 7'h00); wr(2'd0, 7'h60);
    endtask

    // R3, R4: periodic flag spacing for one divider/rate pair
    task automatic t_period(input logic [2:0] dv, input logic [3:0] code,
                            input int strd, input int exp_p, input bit first,
                            input string tag);
        logic [7:0] d;
        int c0, t1, t2;
        bit ok;
        stride = strd;
        wr(2'd0, 7'h60);
        wr(2'd1, 7'h40);
        rd(2'd2, d);
        wr(2'd0, {dv, code});
        c0 = cyc;
        wait_irq(exp_p * 3 + 20, t1, ok);
        chk(ok, 1, {tag, " first flag"});
        if (first) chk(t1 - c0, exp_p, {tag, " R4 first latency"});
        rd(2'd2, d);
        chk(d[7:6], 2'b11, {tag, " R5 periodic flag bits"});
        wait_irq(exp_p * 3 + 20, t2, ok);
        chk(t2 - t1, exp_p, {tag, " R3 spacing"});
        wr(2'd0, 7'h60);
        rd(2'd2, d);
        stride = 1;
    endtask

    task automatic t_div_reset();
        logic [7:0] d;
        wr(2'd1, 7'h48);
        wr(2'd0, 7'h63);
        idle(3000);
        chk(irq, 0, "R4 divider 6 no irq");
        chk(sqw, 0, "R4 divider 6 sqw low");
        wr(2'd0, 7'h33);
        idle(3000);
        rd(2'd2, d); chk(d, 0, "R4 divider 3 no flag");
        wr(2'd0, 7'h60); wr(2'd1, 7'h00);
    endtask

    task automatic t_rate_zero();
        logic [7:0] d;
        wr(2'd1, 7'h48);
        wr(2'd0, 7'h00);
        idle(3000);
        chk(irq, 0, "R2 rate 0 irq");
        chk(sqw, 0, "R2 rate 0 sqw");
        rd(2'd2, d); chk(d, 0, "R2 rate 0 flags");
        wr(2'd0, 7'h60); wr(2'd1, 7'h00);
    endtask

    task automatic t_square();
        logic [7:0] d;
        logic s0;
        int ta, tb;
        bit ok_a, ok_b;
        wr(2'd1, 7'h08);
        wr(2'd0, 7'h01);
        ok_a = 0; ok_b = 0; ta = 0; tb = 0;
        s0 = sqw;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #2;
            if (sqw != s0) begin ok_a = 1; ta = cyc; s0 = sqw; break; end
        end
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #2;
            if (sqw != s0) begin ok_b = 1; tb = cyc; break; end
        end
        chk(ok_a && ok_b, 1, "R8 sqw toggles");
        chk(tb - ta, 64, "R8 half period");
        chk(irq, 0, "R6 periodic flag masked");
        rd(2'd2, d); chk(d, 8'h40, "R5 flag set without enable");
        wr(2'd1, 7'h00);
        idle(200);
        chk(sqw, 0, "R8 sqw off when disabled");
        wr(2'd0, 7'h60);
        rd(2'd2, d);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        wr(2'd0, 7'h60); wr(2'd1, 7'h00); rd(2'd2, d);
        pulse(1'b1);
        chk(irq, 0, "R6 alarm masked");
        rd(2'd2, d); chk(d, 8'h20, "R5 alarm flag");
        rd(2'd2, d); chk(d, 0, "R7 cleared after read");
        wr(2'd1, 7'h20);
        pulse(1'b1);
        chk(irq, 1, "R6 alarm enabled irq");
        rd(2'd2, d); chk(d, 8'hA0, "R6 request bit");
        chk(irq, 0, "R7 irq drops after read");
        wr(2'd1, 7'h10);
        pulse(1'b0);
        rd(2'd2, d); chk(d, 8'h90, "R6 update request");
        wr(2'd1, 7'h00);
        // R7: event in the same cycle as the clearing read survives
        @(negedge clk);
        addr = 2'd2; rd_en = 1'b1; update_evt = 1'b1;
        #1 d = rdata;
        @(posedge clk); #2;
        rd_en = 1'b0; update_evt = 1'b0;
        chk(d, 0, "R7 read before event");
        rd(2'd2, d); chk(d, 8'h10, "R7 event kept");
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset_state();
        t_reg_access();
        t_period(3'd0, 4'd1, 1, 128, 1'b1, "R3 fast code1");
        t_period(3'd0, 4'd3, 1, 512, 1'b1, "R3 fast code3");
        t_period(3'd1, 4'd2, 1, 64, 1'b1, "R3 mid code2");
        t_period(3'd2, 4'd1, 1, 128, 1'b1, "R3 slow code1");
        t_period(3'd2, 4'd2, 1, 256, 1'b1, "R3 slow code2");
        t_period(3'd2, 4'd3, 8, 32, 1'b0, "R3 slow code3");
        t_period(3'd2, 4'd15, 1, 16384, 1'b1, "R3 slow code15");
        t_div_reset();
        t_rate_zero();
        t_square();
        t_flags();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule